// File: doc/BRIEF.md
# Flash Cache Control and Status Registers

This block is the register front end of a flash execute-in-place cache. A bus master reads and writes a small set of word registers through a simple request/ready port. The registers hold the cache enable, power-down and bad-write fault policy levels. They also hold a self-clearing flush trigger, a status word with a flush-ready flag, and two saturating event counters. The counters are fed by single-cycle hit and access pulses from the cache datapath.

A write to the flush register starts a tag-clear walk. The walk presents one tag index per cycle on a clear strobe until every line has been covered. A walk also runs on its own out of reset. While a walk is in progress, a read of the flush register is held off until the walk ends, so software can block on the flush simply by reading it. The block also reports whether a direct access to the cache storage used as plain RAM must be refused.

Top module: `flashCacheCsr`

## Requirements
- R1: Out of reset the control word reads 0x3: enable (bit 0) is 1, bad-write fault (bit 1) is 1 and power-down (bit 3) is 0. The status word (bit 0 = flush ready) reads 0, because a walk starts at reset.
- R2: A control write sets enable to written bit 0 AND NOT written bit 3. Enable is never 1 while power-down is 1. The three levels appear on the enable, power-down and fault outputs from the cycle after the write.
- R3: A direct RAM-mode access request is refused (sramDenied = 1) whenever the cache is enabled or powered down. Otherwise it is allowed.
- R4: A write with bit 0 set to the flush register at word offset 0x04 starts a walk. The walk asserts tagClrEn for exactly NUM_LINES consecutive cycles, with tagClrIdx counting 0, 1, … NUM_LINES-1.
- R5: Flush ready (status bit 0) is 0 during a walk. It is 1 from the cycle after the last index is presented.
- R6: A read of the flush register keeps busReady low while a walk is in progress and then returns 0. A read in the idle state completes in the first cycle.
- R7: The hit counter (offset 0x0C) increments by one per hitPulse cycle. The access counter (offset 0x10) increments by one per accPulse cycle.
- R8: Each counter stops at its all-ones value and does not wrap.
- R9: A write of any value to a counter clears it to zero. The clear takes priority over a pulse in the same cycle.
- R10: A flush write during a walk restarts the walk at index 0 on the following cycle.
- R11: Register word offsets are control 0x00, flush 0x04, status 0x08, hit 0x0C, access 0x10. Any other or misaligned address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Register access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid while busReady |
| busReady | output | 1 | Access completes on the edge where this is high |
| hitPulse | input | 1 | One cache hit this cycle |
| accPulse | input | 1 | One cache access this cycle |
| sramReq | input | 1 | Direct RAM-mode access attempted |
| sramDenied | output | 1 | That access must be answered with an error |
| cacheEnable | output | 1 | Cache enable level |
| cachePowerDown | output | 1 | Cache memories powered down |
| badWriteFault | output | 1 | Fault policy for writes to non-allocating aliases |
| tagClrEn | output | 1 | Tag entry at tagClrIdx is cleared this cycle |
| tagClrIdx | output | IDX_W | Tag index being cleared |

## Verification
The bench builds the block with NUM_LINES = 8 and CNT_W = 4. With eight lines, the stall of a flush read can be counted cycle by cycle, and the index sequence after a restart can be compared entry by entry. With four-bit counters, saturation is reached after fifteen pulses, so the stop at all-ones and a clear from the saturated value are both exercised within a short run.

// File: rtl/flash_cache_csr_pkg.sv
package flash_cache_csr_pkg;

  // word offsets of the registers (byte address >> 2)
  localparam int unsigned WORD_CTRL  = 0;
  localparam int unsigned WORD_FLUSH = 1;
  localparam int unsigned WORD_STAT  = 2;
  localparam int unsigned WORD_HIT   = 3;
  localparam int unsigned WORD_ACC   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_FLUSH,
    SEL_STAT,
    SEL_HIT,
    SEL_ACC
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrCtrl;
    logic    newEn;
    logic    newErr;
    logic    newPd;
    logic    clrHit;
    logic    clrAcc;
    regSel_e rdSel;
  } csrStrobe_t;

endpackage

// File: rtl/fccFlushWalk.sv
module fccFlushWalk #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busy,
  output logic             clrEn,
  output logic [IDX_W-1:0] clrIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign clrEn  = busy;
  assign clrIdx = idx;

  a_r5_ready_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx == LAST_IDX && !start) |=> !busy);

  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && idx == '0));

  a_r4_index_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx != LAST_IDX && !start) |=> (busy && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/fccSatCounter.sv
module fccSatCounter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && count != MAX_VAL) begin
      count <= count + 1'b1;
    end
  end

  a_r8_hold_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (count == MAX_VAL && !clr) |=> count == MAX_VAL);

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> count == '0);

  a_r7_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && count != MAX_VAL) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/fccControl.sv
module fccControl
  import flash_cache_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WIDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              flushBusy,
  output logic              flushStart,
  output logic              busReady,
  output csrStrobe_t        strobe
);

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;
  regSel_e           sel;
  logic              doWrite;
  logic              unusedData;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign aligned    = (busAddr[1:0] == 2'b00);
  assign unusedData = ^{busWdata[DATA_W-1:4], busWdata[2]};

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if      (wordIdx == WIDX_W'(WORD_CTRL))  sel = SEL_CTRL;
      else if (wordIdx == WIDX_W'(WORD_FLUSH)) sel = SEL_FLUSH;
      else if (wordIdx == WIDX_W'(WORD_STAT))  sel = SEL_STAT;
      else if (wordIdx == WIDX_W'(WORD_HIT))   sel = SEL_HIT;
      else if (wordIdx == WIDX_W'(WORD_ACC))   sel = SEL_ACC;
    end
  end

  assign doWrite    = busReq && busWrite;
  assign flushStart = doWrite && (sel == SEL_FLUSH) && busWdata[0];
  assign busReady   = !(busReq && !busWrite && (sel == SEL_FLUSH) && flushBusy);

  always_comb begin
    strobe        = '0;
    strobe.wrCtrl = doWrite && (sel == SEL_CTRL);
    strobe.newEn  = busWdata[0];
    strobe.newErr = busWdata[1];
    strobe.newPd  = busWdata[3];
    strobe.clrHit = doWrite && (sel == SEL_HIT);
    strobe.clrAcc = doWrite && (sel == SEL_ACC);
    strobe.rdSel  = sel;
  end

  a_r6_flush_read_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && busAddr == ADDR_W'(WORD_FLUSH * 4) && flushBusy) |-> !busReady);

  a_r6_idle_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !flushBusy |-> busReady);

endmodule

// File: rtl/fccDatapath.sv
module fccDatapath
  import flash_cache_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic              flushBusy,
  input  logic              hitPulse,
  input  logic              accPulse,
  input  logic              sramReq,
  output logic              sramDenied,
  output logic              cacheEnable,
  output logic              cachePowerDown,
  output logic              badWriteFault,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned NUM_CNT = 2;

  logic enReg, errReg, pdReg;
  logic [NUM_CNT-1:0] cntInc, cntClr;
  logic [CNT_W-1:0]   cntVal [NUM_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b1;
      errReg <= 1'b1;
      pdReg  <= 1'b0;
    end else if (strobe.wrCtrl) begin
      enReg  <= strobe.newEn && !strobe.newPd;
      errReg <= strobe.newErr;
      pdReg  <= strobe.newPd;
    end
  end

  assign cntInc = {accPulse, hitPulse};
  assign cntClr = {strobe.clrAcc, strobe.clrHit};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    fccSatCounter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (cntClr[g]),
      .inc   (cntInc[g]),
      .count (cntVal[g])
    );
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_CTRL: begin
        rdData[0] = enReg;
        rdData[1] = errReg;
        rdData[3] = pdReg;
      end
      SEL_STAT: rdData[0] = !flushBusy;
      SEL_HIT:  rdData = DATA_W'(cntVal[0]);
      SEL_ACC:  rdData = DATA_W'(cntVal[1]);
      default:  rdData = '0;
    endcase
  end

  assign cacheEnable    = enReg;
  assign cachePowerDown = pdReg;
  assign badWriteFault  = errReg;
  assign sramDenied     = sramReq && (enReg || pdReg);

  a_r2_no_enable_when_down: assert property (@(posedge clk) disable iff (!rstN)
    !(enReg && pdReg));

  a_r2_pd_write_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && strobe.newPd) |=> (pdReg && !enReg));

  a_r3_sram_refused: assert property (@(posedge clk) disable iff (!rstN)
    (sramReq && (cacheEnable || cachePowerDown)) |-> sramDenied);

endmodule

// File: rtl/flashCacheCsr.sv
module flashCacheCsr
  import flash_cache_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  input  logic              hitPulse,
  input  logic              accPulse,
  input  logic              sramReq,
  output logic              sramDenied,
  output logic              cacheEnable,
  output logic              cachePowerDown,
  output logic              badWriteFault,
  output logic              tagClrEn,
  output logic [IDX_W-1:0]  tagClrIdx
);

  csrStrobe_t strobe;
  logic       flushStart;
  logic       flushBusy;

  fccControl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .flushBusy  (flushBusy),
    .flushStart (flushStart),
    .busReady   (busReady),
    .strobe     (strobe)
  );

  fccFlushWalk #(.NUM_LINES(NUM_LINES)) u_walk (
    .clk    (clk),
    .rstN   (rstN),
    .start  (flushStart),
    .busy   (flushBusy),
    .clrEn  (tagClrEn),
    .clrIdx (tagClrIdx)
  );

  fccDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .flushBusy      (flushBusy),
    .hitPulse       (hitPulse),
    .accPulse       (accPulse),
    .sramReq        (sramReq),
    .sramDenied     (sramDenied),
    .cacheEnable    (cacheEnable),
    .cachePowerDown (cachePowerDown),
    .badWriteFault  (badWriteFault),
    .rdData         (busRdata)
  );

endmodule

// File: tb/flashCacheCsr_tb.sv
module flashCacheCsr_tb;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned NLINES = 8;
  localparam int unsigned IDX_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_FLUSH = 5'h04;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h08;
  localparam logic [ADDR_W-1:0] A_HIT   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_ACC   = 5'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic busReady;
  logic hitPulse = 1'b0, accPulse = 1'b0, sramReq = 1'b0;
  logic sramDenied, cacheEnable, cachePowerDown, badWriteFault, tagClrEn;
  logic [IDX_W-1:0] tagClrIdx;

  int nVec = 0;
  int nFail = 0;
  bit finished = 0;

  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];
  int                idxLog[$];

  always #5 clk = ~clk;

  flashCacheCsr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_LINES(NLINES)) u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .hitPulse(hitPulse), .accPulse(accPulse), .sramReq(sramReq), .sramDenied(sramDenied),
    .cacheEnable(cacheEnable), .cachePowerDown(cachePowerDown), .badWriteFault(badWriteFault),
    .tagClrEn(tagClrEn), .tagClrIdx(tagClrIdx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: completes read transactions against the scoreboard
  always @(negedge clk) begin
    if (rstN && busReq && !busWrite && busReady) begin
      logic [DATA_W-1:0] e;
      string t;
      if (expQ.size() == 0) begin
        check(0, "SCOREBOARD", int'(busRdata), 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata === e, t, int'(busRdata), int'(e));
      end
    end
    if (rstN && tagClrEn) idxLog.push_back(int'(tagClrIdx));
  end

  // all tasks start and end one time unit after a rising edge
  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    busReq = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    @(posedge clk); #1;
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                       input string t, output int stalls);
    expQ.push_back(e); tagQ.push_back(t);
    busReq = 1'b1; busWrite = 1'b0; busAddr = a;
    stalls = 0;
    forever begin
      @(negedge clk);
      if (busReady) break;
      stalls++;
    end
    @(posedge clk); #1;
    busReq = 1'b0;
  endtask

  task automatic pulse(input logic h, input logic ac);
    hitPulse = h; accPulse = ac;
    @(posedge clk); #1;
    hitPulse = 1'b0; accPulse = 1'b0;
  endtask

  task automatic checkWalk(input string req, input int prefix[$]);
    int expSeq[$];
    expSeq = prefix;
    for (int i = 0; i < NLINES; i++) expSeq.push_back(i);
    check(idxLog.size() == expSeq.size(), req, idxLog.size(), expSeq.size());
    for (int i = 0; i < expSeq.size() && i < idxLog.size(); i++)
      check(idxLog[i] == expSeq[i], req, idxLog[i], expSeq[i]);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nVec++; nFail++;
    $display("FAIL WATCHDOG: actual timeout expected completion");
    finish();
  end

  initial begin
    int st;
    int none[$];
    int one0[$];
    one0.push_back(0);

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset levels
    check(cacheEnable === 1'b1, "R1 enable", cacheEnable, 1);
    check(badWriteFault === 1'b1, "R1 fault", badWriteFault, 1);
    check(cachePowerDown === 1'b0, "R1 powerdown", cachePowerDown, 0);
    busRd(A_CTRL, 32'h3, "R1 ctrl reset", st);
    busRd(A_STAT, 32'h0, "R1 R5 status during reset walk", st);
    busRd(A_FLUSH, 32'h0, "R6 flush read after reset", st);
    checkWalk("R4 reset walk", none);
    busRd(A_STAT, 32'h1, "R5 status after walk", st);

    // R4 R5 R6: explicit flush with blocking read
    idxLog.delete();
    busWr(A_FLUSH, 32'h1);
    busRd(A_FLUSH, 32'h0, "R6 flush read data", st);
    check(st == NLINES, "R6 R5 stall cycles", st, NLINES);
    checkWalk("R4 flush walk", none);
    busRd(A_FLUSH, 32'h0, "R6 idle flush read", st);
    check(st == 0, "R6 idle no stall", st, 0);

    // R10: restart during a walk
    idxLog.delete();
    busWr(A_FLUSH, 32'h1);
    busWr(A_FLUSH, 32'h1);
    busRd(A_FLUSH, 32'h0, "R10 wait", st);
    checkWalk("R10 restart sequence", one0);

    // R2 R3: control writes
    busWr(A_CTRL, 32'hB);
    check(cacheEnable === 1'b0 && cachePowerDown === 1'b1, "R2 pd forces en low",
          {cacheEnable, cachePowerDown}, 1);
    busRd(A_CTRL, 32'hA, "R2 ctrl readback pd", st);
    sramReq = 1'b1; #1;
    check(sramDenied === 1'b1, "R3 denied when powered down", sramDenied, 1);
    busWr(A_CTRL, 32'h0);
    check(sramDenied === 1'b0, "R3 allowed when off and up", sramDenied, 0);
    check(badWriteFault === 1'b0, "R2 fault cleared", badWriteFault, 0);
    busRd(A_CTRL, 32'h0, "R2 ctrl readback zero", st);
    busWr(A_CTRL, 32'h1);
    check(sramDenied === 1'b1 && cacheEnable === 1'b1, "R3 denied when enabled", sramDenied, 1);
    sramReq = 1'b0;
    busWr(A_CTRL, 32'h2);
    busRd(A_CTRL, 32'h2, "R2 fault only", st);

    // R7: counting
    pulse(1, 1); pulse(1, 1); pulse(1, 1); pulse(0, 1); pulse(0, 1);
    busRd(A_HIT, 32'd3, "R7 hit count", st);
    busRd(A_ACC, 32'd5, "R7 access count", st);

    // R8: saturation
    for (int i = 0; i < 20; i++) pulse(1, 1);
    busRd(A_HIT, 32'hF, "R8 hit saturates", st);
    busRd(A_ACC, 32'hF, "R8 access saturates", st);

    // R9: clear wins over pulse
    accPulse = 1'b1;
    busWr(A_ACC, 32'h1234);
    accPulse = 1'b0;
    busRd(A_ACC, 32'h0, "R9 clear wins", st);
    busRd(A_HIT, 32'hF, "R9 other counter kept", st);
    busWr(A_HIT, 32'h0);
    busRd(A_HIT, 32'h0, "R9 write zero clears", st);

    // R11: map
    busRd(5'h14, 32'h0, "R11 unmapped", st);
    busRd(5'h02, 32'h0, "R11 misaligned", st);
    busRd(A_STAT, 32'h1, "R11 status offset", st);

    repeat (2) @(posedge clk);
    check(expQ.size() == 0, "SCOREBOARD drained", expQ.size(), 0);
    finish();
  end

endmodule